// File: doc/BRIEF.md
# Two-Wire Slave Receiver with Event Status Codes

This block is the receive side of a two-wire (I2C) slave. It follows the bus through synchronized copies of SCL and SDA and recognizes START and STOP conditions. After each START it shifts in a seven-bit address and a direction bit. It acknowledges the address if the address equals the programmed own address with a write direction. It also acknowledges the all-zero general-call address when general-call response is enabled. After that it captures the data bytes that follow.

Software steps the transfer forward through a flag and a status byte. Each significant bus event loads an 8-bit code into the status byte and raises the flag. After an address or data acknowledge cycle the block also holds SCL low until software clears the flag with a one-cycle pulse. An acknowledge-enable input is read at each decision point. With it low the block returns NACK to the next data byte, or ignores its own address. Once a data byte has been NACKed, the block stays silent until the next STOP or repeated START.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset, flag_o is 0, status_o reads 0xF8, and neither SCL nor SDA is driven. status_o reads 0xF8 whenever flag_o is 0.
- R2: A START followed by the own address in bits [7:1] and a write direction bit 0 in bit 0 is ACKed by driving SDA low during the ninth clock. Then flag_o is set with status 0x60.
- R3: The address byte 0x00 is ACKed with status 0x70 when gc_en_i is 1. It is NACKed with no flag when gc_en_i is 0.
- R4: A non-matching address, or the own address with direction bit 1, is NACKed and sets no flag. Data bytes that follow are neither ACKed nor flagged.
- R5: An ACKed data byte appears on data_o. The status is 0x80 after an own-address write or 0x90 after a general call.
- R6: If ack_en_i is 0 when a data byte completes, the byte is still captured on data_o but NACKed, with status 0x88 (own address) or 0x98 (general call). Later bytes up to the next STOP or START are ignored.
- R7: While ack_en_i is 0 the own address is not ACKed. Setting it again restores recognition at the next START.
- R8: After an address or data event, SCL is held low for as long as flag_o is 1. flag_o stays set until a flag_clr_i pulse, and SCL is then released.
- R9: A STOP or repeated START while addressed (address ACKed and no data NACK since) sets flag_o with status 0xA0 and does not stretch SCL.
- R10: With en_i at 0 the block drives neither line, keeps flag_o at 0 and does not respond to its address.
- R11: status_o only takes the values 0xF8, 0x60, 0x70, 0x80, 0x88, 0x90, 0x98 and 0xA0. The code 0x68 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable |
| ack_en_i | input | 1 | Acknowledge enable |
| gc_en_i | input | 1 | Respond to general-call address |
| own_addr_i | input | 7 | Own slave address |
| flag_clr_i | input | 1 | One-cycle pulse clearing the event flag |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low (stretch) |
| sda_oe_o | output | 1 | Pull SDA low (ACK) |
| flag_o | output | 1 | Event flag |
| status_o | output | 8 | Event status code |
| data_o | output | 8 | Last received data byte |

## Verification
A bit counter or shift register that falls out of step shows up first at the ACK slot. Either SDA is pulled low in the wrong clock, or the address compare misses, so the master samples the wrong ACK within nine SCL periods of the fault. A wrong address/data phase or a stale addressed state shows up as a status code that differs from the bench model at the next flag, or as a missing or extra 0xA0 at the following STOP. A flag that is not cleared correctly leaves SCL stretched, which stalls the master and trips the watchdog.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;
  typedef enum logic [7:0] {
    ST_SLA_W      = 8'h60,
    ST_ARB_SLA_W  = 8'h68,  // defined, never raised by a slave-only block
    ST_GC         = 8'h70,
    ST_DAT_ACK    = 8'h80,
    ST_DAT_NACK   = 8'h88,
    ST_GC_ACK     = 8'h90,
    ST_GC_NACK    = 8'h98,
    ST_STOP       = 8'hA0,
    ST_IDLE       = 8'hF8
  } status_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_DATA, S_DATA_ACK, S_SKIP
  } state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
    logic sda;
  } bus_ev_t;
endpackage

// File: rtl/i2c_srx_sync.sv
module i2c_srx_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] in_i,
  output logic [LINES-1:0] out_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '1;  // idle bus level
      else         ff_q <= {ff_q[STAGES-2:0], in_i[g]};
    end
    assign out_o[g] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_srx_edge.sv
module i2c_srx_edge
  import i2c_srx_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    ev_o.start = scl_q & scl_i & sda_q & ~sda_i;
    ev_o.stop  = scl_q & scl_i & ~sda_q & sda_i;
    ev_o.rise  = ~scl_q & scl_i;
    ev_o.fall  = scl_q & ~scl_i;
    ev_o.sda   = sda_i;
  end
endmodule

// File: rtl/i2c_srx_ctrl.sv
module i2c_srx_ctrl
  import i2c_srx_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ack_en_i,
  input  logic              gc_en_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              flag_clr_i,
  input  bus_ev_t           ev_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              flag_o,
  output logic [7:0]        status_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W);

  state_e            state_q;
  status_e           code_q;
  logic [DATA_W-1:0] sh_q, data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              flag_q, stretch_q, sda_oe_q, gc_q, ack_q, addressed_q;
  logic              own_hit, gc_hit, addr_hit;

  assign own_hit  = (sh_q[ADDR_W:1] == own_addr_i) && !sh_q[0];
  assign gc_hit   = gc_en_i && (sh_q == '0);
  assign addr_hit = ack_en_i && (own_hit || gc_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      code_q      <= ST_IDLE;
      sh_q        <= '0;
      data_q      <= '0;
      cnt_q       <= '0;
      flag_q      <= 1'b0;
      stretch_q   <= 1'b0;
      sda_oe_q    <= 1'b0;
      gc_q        <= 1'b0;
      ack_q       <= 1'b0;
      addressed_q <= 1'b0;
    end else if (!en_i) begin
      state_q     <= S_IDLE;
      flag_q      <= 1'b0;
      stretch_q   <= 1'b0;
      sda_oe_q    <= 1'b0;
      addressed_q <= 1'b0;
    end else begin
      if (flag_clr_i) flag_q <= 1'b0;
      if (ev_i.start || ev_i.stop) begin
        if (addressed_q) begin
          flag_q    <= 1'b1;
          stretch_q <= 1'b0;
          code_q    <= ST_STOP;
        end
        addressed_q <= 1'b0;
        sda_oe_q    <= 1'b0;
        cnt_q       <= '0;
        state_q     <= ev_i.start ? S_ADDR : S_IDLE;
      end else begin
        unique case (state_q)
          S_ADDR, S_DATA: begin
            if (ev_i.rise && cnt_q != CNT_LAST) begin
              sh_q  <= {sh_q[DATA_W-2:0], ev_i.sda};
              cnt_q <= cnt_q + CNT_W'(1);
            end else if (ev_i.fall && cnt_q == CNT_LAST) begin
              if (state_q == S_ADDR) begin
                if (addr_hit) begin
                  sda_oe_q <= 1'b1;
                  gc_q     <= !own_hit;
                  state_q  <= S_ADDR_ACK;
                end else begin
                  state_q  <= S_SKIP;
                end
              end else begin
                data_q   <= sh_q;  // captured even when NACKed
                sda_oe_q <= ack_en_i;
                ack_q    <= ack_en_i;
                state_q  <= S_DATA_ACK;
              end
            end
          end
          S_ADDR_ACK: if (ev_i.fall) begin
            sda_oe_q    <= 1'b0;
            flag_q      <= 1'b1;
            stretch_q   <= 1'b1;
            code_q      <= gc_q ? ST_GC : ST_SLA_W;
            addressed_q <= 1'b1;
            cnt_q       <= '0;
            state_q     <= S_DATA;
          end
          S_DATA_ACK: if (ev_i.fall) begin
            sda_oe_q  <= 1'b0;
            flag_q    <= 1'b1;
            stretch_q <= 1'b1;
            cnt_q     <= '0;
            if (gc_q) code_q <= ack_q ? ST_GC_ACK : ST_GC_NACK;
            else      code_q <= ack_q ? ST_DAT_ACK : ST_DAT_NACK;
            if (ack_q) state_q <= S_DATA;
            else begin
              state_q     <= S_SKIP;
              addressed_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign flag_o   = flag_q;
  assign status_o = flag_q ? code_q : ST_IDLE;
  assign scl_oe_o = flag_q && stretch_q;
  assign sda_oe_o = sda_oe_q;
  assign data_o   = data_q;
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2c_srx_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = ADDR_W + 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ack_en_i,
  input  logic              gc_en_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              flag_clr_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              flag_o,
  output logic [7:0]        status_o,
  output logic [DATA_W-1:0] data_o
);
  logic [1:0] line_s;
  bus_ev_t    ev;

  i2c_srx_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  ({scl_i, sda_i}),
    .out_o (line_s)
  );

  i2c_srx_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (line_s[1]),
    .sda_i (line_s[0]),
    .ev_o  (ev)
  );

  i2c_srx_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .ack_en_i  (ack_en_i),
    .gc_en_i   (gc_en_i),
    .own_addr_i(own_addr_i),
    .flag_clr_i(flag_clr_i),
    .ev_i      (ev),
    .scl_oe_o  (scl_oe_o),
    .sda_oe_o  (sda_oe_o),
    .flag_o    (flag_o),
    .status_o  (status_o),
    .data_o    (data_o)
  );
endmodule

// File: rtl/i2c_slave_rx_chk.sv
module i2c_slave_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       ack_en_i,
  input logic       flag_clr_i,
  input logic       scl_oe_o,
  input logic       sda_oe_o,
  input logic       flag_o,
  input logic [7:0] status_o
);
  AST_NO_ARB_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o != 8'h68); // R11
  AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |-> status_o inside {8'h60, 8'h70, 8'h80, 8'h88, 8'h90, 8'h98, 8'hA0}); // R11
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !flag_clr_i && en_i |=> flag_o); // R8
  AST_FLAG_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> $past(flag_clr_i) || !$past(en_i)); // R8
  AST_STRETCH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_oe_o |-> flag_o); // R8
  AST_ACK_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(ack_en_i)); // R7
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sda_oe_o && !scl_oe_o && !flag_o); // R10
endmodule

bind i2c_slave_rx i2c_slave_rx_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .ack_en_i  (ack_en_i),
  .flag_clr_i(flag_clr_i),
  .scl_oe_o  (scl_oe_o),
  .sda_oe_o  (sda_oe_o),
  .flag_o    (flag_o),
  .status_o  (status_o)
);

// File: tb/i2c_slave_rx_test.sv
`timescale 1ns/1ps
module i2c_slave_rx_test;
  localparam int Q = 8;
  localparam logic [6:0] OWN = 7'h3A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, ack_en = 1'b1, gc_en = 1'b1, flag_clr = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe, flag;
  logic [7:0] status, data;
  wire scl_line = scl_m & ~scl_oe;
  wire sda_line = sda_m & ~sda_oe;

  int n_run = 0, n_fail = 0, bad_code = 0;
  bit addressed, gc_xfer;

  always #5 clk = ~clk;

  i2c_slave_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .ack_en_i(ack_en), .gc_en_i(gc_en),
    .own_addr_i(OWN), .flag_clr_i(flag_clr), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .flag_o(flag), .status_o(status), .data_o(data)
  );

  always @(negedge clk)
    if (rst_n && !(status inside {8'hF8, 8'h60, 8'h70, 8'h80, 8'h88, 8'h90, 8'h98, 8'hA0}))
      bad_code++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic wait_high(); while (!scl_line) @(negedge clk); endtask

  task automatic clk_bit(input bit b, output bit rd);
    sda_m = b; wq();
    scl_m = 1'b1; wait_high(); wq();
    rd = sda_line;
    scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    bit d;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], d);
    clk_bit(1'b1, d);
    ack = !d;
    wq();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wait_high(); wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wait_high(); wq();
    sda_m = 1'b1; wq(); wq();
  endtask

  task automatic sw_clear();
    flag_clr = 1'b1; @(negedge clk);
    flag_clr = 1'b0; @(negedge clk);
  endtask

  function automatic bit exp_hit(input logic [7:0] a);
    return en && ack_en && ((a[7:1] == OWN && !a[0]) || (gc_en && a == 8'h00));
  endfunction

  function automatic logic [7:0] exp_code(input bit gc, input bit ack);
    if (gc) return ack ? 8'h90 : 8'h98;
    return ack ? 8'h80 : 8'h88;
  endfunction

  // address phase: model decides ACK and code
  task automatic do_addr(input logic [7:0] a, input string req);
    bit ack, hit;
    hit = exp_hit(a);
    send_byte(a, ack);
    chk(req, ack, hit);
    chk(req, flag, hit);
    if (hit) begin
      chk(req, status, (a == 8'h00) ? 8'h70 : 8'h60);
      sw_clear();
    end
    addressed = hit;
    gc_xfer = (a == 8'h00);
  endtask

  task automatic do_data(input logic [7:0] v, input string req);
    bit ack;
    bit eack;
    eack = ack_en;
    send_byte(v, ack);
    if (addressed) begin
      chk(req, ack, eack);
      chk(req, flag, 1);
      chk(req, status, exp_code(gc_xfer, eack));
      chk(req, data, v);
      sw_clear();
      if (!eack) addressed = 0;
    end else begin
      chk(req, ack, 0);
      chk(req, flag, 0);
    end
  endtask

  task automatic do_stop(input string req);
    bus_stop();
    if (addressed) begin
      chk(req, status, 8'hA0);
      chk(req, scl_oe, 0);
      sw_clear();
    end else begin
      chk(req, flag, 0);
      chk(req, status, 8'hF8);
    end
    addressed = 0;
  endtask

  initial begin
    repeat (Q * 400000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", flag, 0);
    chk("R1", status, 8'hF8);
    chk("R1", {scl_oe, sda_oe}, 2'b00);

    // R2 R5 R9 own address write, two bytes, stop
    bus_start(); do_addr({OWN, 1'b0}, "R2");
    do_data(8'hA5, "R5"); do_data(8'h3C, "R5");
    do_stop("R9");

    // R3 general call enabled, then disabled
    bus_start(); do_addr(8'h00, "R3"); do_data(8'h5A, "R5"); do_stop("R9");
    gc_en = 1'b0;
    bus_start(); do_addr(8'h00, "R3"); do_data(8'h11, "R3"); do_stop("R3");
    gc_en = 1'b1;

    // R4 wrong address and read direction
    bus_start(); do_addr({OWN ^ 7'h01, 1'b0}, "R4"); do_data(8'h22, "R4"); do_stop("R4");
    bus_start(); do_addr({OWN, 1'b1}, "R4"); do_data(8'h33, "R4"); do_stop("R4");

    // R7 ack disabled on address, then recovered
    ack_en = 1'b0;
    bus_start(); do_addr({OWN, 1'b0}, "R7"); do_data(8'h44, "R7"); do_stop("R7");
    ack_en = 1'b1;
    bus_start(); do_addr({OWN, 1'b0}, "R7"); do_stop("R7");

    // R6 ack cleared mid transfer: NACK byte captured, then silence
    bus_start(); do_addr({OWN, 1'b0}, "R6");
    do_data(8'h61, "R6");
    ack_en = 1'b0; do_data(8'h9E, "R6");
    chk("R6", data, 8'h9E);
    ack_en = 1'b1; do_data(8'h77, "R6");
    chk("R6", data, 8'h9E);
    do_stop("R6");
    bus_start(); do_addr(8'h00, "R6"); ack_en = 1'b0; do_data(8'hC3, "R6"); ack_en = 1'b1;
    do_stop("R6");

    // R8 stretching: flag set, SCL held low until cleared
    begin
      bit ack;
      bus_start(); do_addr({OWN, 1'b0}, "R8");
      send_byte(8'h0F, ack);
      chk("R8", ack, 1);
      chk("R8", status, 8'h80);
      sda_m = 1'b0; wq();
      scl_m = 1'b1;
      repeat (50) @(negedge clk);
      chk("R8", scl_line, 0);
      chk("R8", flag, 1);
      sw_clear(); wq();
      chk("R8", scl_line, 1);
      wq(); sda_m = 1'b1; wq(); wq();
      chk("R9", status, 8'hA0);
      sw_clear();
      addressed = 0;
    end

    // R9 repeated start while addressed
    bus_start(); do_addr({OWN, 1'b0}, "R9"); do_data(8'hD2, "R5");
    bus_start();
    chk("R9", status, 8'hA0);
    chk("R9", scl_oe, 0);
    sw_clear();
    addressed = 0;
    do_addr({OWN, 1'b0}, "R9"); do_data(8'hE1, "R5"); do_stop("R9");

    // R10 disabled
    en = 1'b0;
    begin
      bit ack;
      bus_start(); send_byte({OWN, 1'b0}, ack);
      chk("R10", ack, 0); chk("R10", flag, 0); chk("R10", sda_oe, 0);
      bus_stop();
    end
    en = 1'b1;

    // random transfers
    for (int t = 0; t < 30; t++) begin
      logic [7:0] a;
      int nb;
      int pick;
      pick = $urandom_range(0, 9);
      gc_en = ($urandom_range(0, 3) != 0);
      ack_en = ($urandom_range(0, 5) != 0);
      if (pick < 5)      a = {OWN, 1'(pick == 4)};
      else if (pick < 7) a = 8'h00;
      else               a = 8'($urandom_range(0, 255));
      bus_start(); do_addr(a, "R2");
      nb = $urandom_range(1, 4);
      for (int k = 0; k < nb; k++) begin
        ack_en = ($urandom_range(0, 4) != 0);
        do_data(8'($urandom_range(0, 255)), "R5");
      end
      ack_en = 1'b1;
      do_stop("R9");
    end

    chk("R11", bad_code, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule